// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor that executes 16-bit instructions over a 16-bit datapath. Each instruction passes through a fixed sequence of phases, and a state machine steps through them: read the word at the program counter, latch it, decode it, then run any address, operand, execute and write-back steps the instruction needs. The core holds eight 16-bit general registers, a program counter, an instruction register and three condition flags (negative, zero, positive).

The core has one port to a single synchronous word memory. That memory has 65,536 locations and is addressed by word. The core drives an address, write data and a write enable. Read data returns one cycle after the address is presented. The instruction set covers three register operations, loads and stores in PC-relative, base-plus-offset and double-read indirect forms, address generation, conditional branches, register jumps and a vectored service call. Opcodes that are not listed in the requirements do nothing and fall through.

Top module: `mc16_core`

## Requirements
- R1: While `rst_n` is low and on the cycle it goes high, `mem_addr` equals `RESET_PC` (default x3000) and `mem_we` is 0. After reset the flags read zero-set. The flag code is {n,z,p}, so zero-set is 3'b010.
- R2: Each instruction word is read from the address in the PC. The PC is then incremented by one before the instruction executes, so every PC-relative offset counts from the following word.
- R3: ADD (opcode 0001) and AND (opcode 0101) write DR = IR[11:9] from SR1 = IR[8:6] and a second operand. When IR[5] is 0, that operand is register IR[2:0]. When IR[5] is 1, it is the 5-bit field IR[4:0] sign-extended to 16 bits.
- R4: NOT (opcode 1001, IR[5:0] = 111111) writes the bitwise complement of IR[8:6] into IR[11:9]. The source and the destination may be the same register.
- R5: ADD, AND, NOT, LD, LDI, LDR and LEA set exactly one flag from the value they write to the destination register. The flag is negative if bit 15 is set, zero if the value is 0, and positive otherwise. Stores, branches, jumps and the service call leave the flags unchanged.
- R6: LD (0010) and ST (0011) use the address PC + sext(IR[8:0]). LDR (0110) and STR (0111) use the address reg[IR[8:6]] + sext(IR[5:0]). A store drives `mem_we` for exactly one cycle and writes reg[IR[11:9]].
- R7: LDI (1010) and STI (1011) first read the word at PC + sext(IR[8:0]). They then use that word as the address of the load or the store.
- R8: LEA (1110) writes PC + sext(IR[8:0]) into IR[11:9]. It makes no data access to memory.
- R9: BR (0000) takes IR[11:9] as an {n,z,p} mask. If any masked flag is set, the PC becomes PC + sext(IR[8:0]). Otherwise execution falls through to the next word.
- R10: JMP (1100 000 B 000000) loads the PC with reg[B] unconditionally.
- R11: TRAP (1111 0000 V) saves the incremented PC in R7. It then loads the PC from the memory word at address {8'h00, V}, so a routine ending in JMP R7 returns to the word after the TRAP.
- R12: Two programs must leave the correct results in memory. The first sums twelve words stored from x3100, with its code starting at x3000. The second multiplies two operands by repeated addition, including a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address to memory |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable, one cycle per store |

## Verification
The bench runs random chains of register operations that use immediates of both signs, including -16. It then stores every register and decodes the flags with branches. A wrong sign extension or an inverted operand select would leave a wrong register image or a wrong flag code. The loads and stores run with zero, negative and random data. This exposes a flag update placed on the wrong instruction, a double-read indirect access that uses the pointer as the data, and a base offset that is not sign-extended. The jump and service-call program skips a word and returns through R7. A core that saved the un-incremented PC would loop on the call forever, and one that indexed the vector table wrongly would run off into empty memory. Neither would leave the marker values the bench expects.

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core #(
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic        mem_we
);
  localparam logic [2:0] S_FETCH = 3'd0, S_IR = 3'd1, S_DEC = 3'd2, S_INDA = 3'd3,
                         S_INDW = 3'd4, S_MEMA = 3'd5, S_MEMW = 3'd6;
  localparam logic [3:0] OP_BR = 4'h0, OP_ADD = 4'h1, OP_LD = 4'h2, OP_ST = 4'h3,
                         OP_AND = 4'h5, OP_LDR = 4'h6, OP_STR = 4'h7, OP_NOT = 4'h9,
                         OP_LDI = 4'hA, OP_STI = 4'hB, OP_JMP = 4'hC, OP_LEA = 4'hE,
                         OP_TRAP = 4'hF;

  logic [2:0]  state, nzp;
  logic [15:0] pc, ir, mar;
  logic [15:0] regs [8];
  logic [3:0]  op;
  logic [15:0] src1, src2, dval, opnd, off9, off6, ea, alu;
  logic        is_store, is_load, wr_en, set_cc;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;

  assign op       = ir[15:12];
  assign src1     = regs[ir[8:6]];
  assign src2     = regs[ir[2:0]];
  assign dval     = regs[ir[11:9]];
  assign off9     = {{7{ir[8]}}, ir[8:0]};
  assign off6     = {{10{ir[5]}}, ir[5:0]};
  assign opnd     = ir[5] ? {{11{ir[4]}}, ir[4:0]} : src2;
  assign ea       = (op == OP_LDR || op == OP_STR) ? src1 + off6 : pc + off9;
  assign is_store = op inside {OP_ST, OP_STR, OP_STI};
  assign is_load  = op inside {OP_LD, OP_LDR, OP_LDI};

  assign mem_addr  = (state == S_FETCH) ? pc : mar;
  assign mem_we    = (state == S_MEMA) && is_store;
  assign mem_wdata = dval;

  always_comb begin
    case (op)
      OP_ADD:  alu = src1 + opnd;
      OP_AND:  alu = src1 & opnd;
      OP_NOT:  alu = ~src1;
      default: alu = ea;
    endcase
  end

  always_comb begin
    wr_en   = 1'b0;
    set_cc  = 1'b0;
    wr_sel  = ir[11:9];
    wr_data = alu;
    if (state == S_DEC && op inside {OP_ADD, OP_AND, OP_NOT, OP_LEA}) begin
      wr_en  = 1'b1;
      set_cc = 1'b1;
    end else if (state == S_DEC && op == OP_TRAP) begin
      wr_en   = 1'b1;
      wr_sel  = 3'd7;
      wr_data = pc;
    end else if (state == S_MEMW && is_load) begin
      wr_en   = 1'b1;
      set_cc  = 1'b1;
      wr_data = mem_rdata;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) regs[wr_sel] <= wr_data;

  always_ff @(posedge clk)
    if (!rst_n)      nzp <= 3'b010;
    else if (set_cc) nzp <= wr_data[15] ? 3'b100 : (wr_data == 16'h0000 ? 3'b010 : 3'b001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      ir    <= 16'h0000;
      mar   <= 16'h0000;
    end else begin
      case (state)
        S_FETCH: state <= S_IR;
        S_IR: begin
          ir    <= mem_rdata;
          pc    <= pc + 16'd1;
          state <= S_DEC;
        end
        S_DEC: begin
          state <= S_FETCH;
          mar   <= ea;
          case (op)
            OP_BR:  if (|(ir[11:9] & nzp)) pc <= pc + off9;
            OP_JMP: pc <= src1;
            OP_LD, OP_LDR, OP_ST, OP_STR: state <= S_MEMA;
            OP_LDI, OP_STI: state <= S_INDA;
            OP_TRAP: begin
              mar   <= {8'h00, ir[7:0]};
              state <= S_MEMA;
            end
            default: ;
          endcase
        end
        S_INDA: state <= S_INDW;
        S_INDW: begin
          mar   <= mem_rdata;
          state <= S_MEMA;
        end
        S_MEMA: state <= is_store ? S_FETCH : S_MEMW;
        S_MEMW: begin
          if (op == OP_TRAP) pc <= mem_rdata;
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/mc16_core_chk.sv
`timescale 1ns/1ps
module mc16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] pc,
  input logic [2:0]  state,
  input logic [2:0]  nzp,
  input logic [3:0]  op,
  input logic [7:0]  vec
);
  localparam logic [2:0] C_IR = 3'd1, C_DEC = 3'd2;

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> nzp == 3'b010);

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IR) |-> $past(mem_addr) == pc);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DEC) |-> pc == $past(pc) + 16'd1);

  assert_flags_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nzp) == 1);

  assert_store_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_trap_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DEC && op == 4'hF) |=> mem_addr == {8'h00, $past(vec)});
endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr), .pc(pc),
  .state(state), .nzp(nzp), .op(ir[15:12]), .vec(ir[7:0])
);

// File: tb/test_mc16_core.sv
`timescale 1ns/1ps
module test_mc16_core;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic mem_we;
  logic ld_en = 1'b0;
  logic [15:0] ld_addr = 16'h0, ld_data = 16'h0;
  logic [15:0] mem [4096];
  logic [15:0] wp;
  int n_chk = 0, n_fail = 0, cyc = 0;

  mc16_core i_mc16_core (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we));

  function automatic logic [11:0] mi(input logic [15:0] a);
    return {a[13], a[10:0]};
  endfunction

  always @(posedge clk) begin
    if (ld_en) mem[mi(ld_addr)] <= ld_data;
    else if (mem_we) mem[mi(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[mi(mem_addr)];
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    ld_addr = a; ld_data = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic emit(input logic [15:0] ins);
    poke(wp, ins);
    wp = wp + 16'd1;
  endtask

  task automatic emit_pcrel(input logic [3:0] op, input logic [2:0] r, input logic [15:0] tgt);
    logic [15:0] off;
    off = tgt - (wp + 16'd1);
    emit({op, r, off[8:0]});
  endtask

  function automatic logic [15:0] e_add_r(input int d, input int s1, input int s2);
    return {4'h1, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] e_add_i(input int d, input int s1, input int imm);
    return {4'h1, 3'(d), 3'(s1), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] e_and_r(input int d, input int s1, input int s2);
    return {4'h5, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] e_and_i(input int d, input int s1, input int imm);
    return {4'h5, 3'(d), 3'(s1), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] e_not(input int d, input int s);
    return {4'h9, 3'(d), 3'(s), 6'h3F};
  endfunction
  function automatic logic [15:0] e_base(input logic [3:0] op, input int r, input int b, input int off);
    return {op, 3'(r), 3'(b), 6'(off)};
  endfunction
  function automatic logic [15:0] e_jmp(input int b);
    return {4'hC, 3'b000, 3'(b), 6'b000000};
  endfunction
  function automatic logic [15:0] sx5(input logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction
  function automatic logic [15:0] fl(input logic [15:0] v);
    return v[15] ? 16'd4 : (v == 16'h0 ? 16'd2 : 16'd1);
  endfunction

  task automatic halt();
    emit_pcrel(4'h0, 3'b111, wp);
  endtask

  // stores the {n,z,p} flag code into tgt, using R0
  task automatic emit_flags(input logic [15:0] tgt);
    logic [15:0] a;
    a = wp;
    emit_pcrel(4'h0, 3'b100, a + 16'd8);
    emit_pcrel(4'h0, 3'b010, a + 16'd5);
    emit(e_and_i(0, 0, 0)); emit(e_add_i(0, 0, 1));
    emit_pcrel(4'h0, 3'b111, a + 16'd10);
    emit(e_and_i(0, 0, 0)); emit(e_add_i(0, 0, 2));
    emit_pcrel(4'h0, 3'b111, a + 16'd10);
    emit(e_and_i(0, 0, 0)); emit(e_add_i(0, 0, 4));
    emit_pcrel(4'h3, 3'd0, tgt);
  endtask

  task automatic clear_area();
    for (int a = 16'h3000; a < 16'h3200; a++) poke(16'(a), 16'h0000);
    wp = 16'h3000;
  endtask

  task automatic run(input int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  logic [15:0] bm [8];

  initial begin
    void'($urandom(32'h1357_2468));
    @(negedge clk);

    // reset state and flags after reset
    clear_area();
    emit_flags(16'h3090);
    halt();
    rst_n = 1'b1;
    #1;
    check("R1 first fetch address", mem_addr, 16'h3000);
    check("R1 no write in reset", {15'h0, mem_we}, 16'h0);
    repeat (80) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 flags zero after reset", mem[mi(16'h3090)], 16'd2);

    // sum of twelve words
    begin
      logic [15:0] sum, loop_a;
      clear_area();
      sum = 16'h0;
      for (int k = 0; k < 12; k++) begin
        logic [15:0] v;
        v = 16'($urandom);
        if (k == 0) v = 16'hFFFF;
        poke(16'h3100 + 16'(k), v);
        sum = sum + v;
      end
      emit_pcrel(4'hE, 3'd1, 16'h3100);
      emit(e_and_i(3, 3, 0));
      emit(e_and_i(2, 2, 0));
      emit(e_add_i(2, 2, 12));
      loop_a = wp;
      emit_pcrel(4'h0, 3'b010, 16'h300A);
      emit(e_base(4'h6, 4, 1, 0));
      emit(e_add_r(3, 3, 4));
      emit(e_add_i(1, 1, 1));
      emit(e_add_i(2, 2, -1));
      emit_pcrel(4'h0, 3'b111, loop_a);
      emit(e_base(4'h7, 3, 1, 0));
      halt();
      run(900);
      check("R12 sum program total (R9 loop)", mem[mi(16'h310C)], sum);
    end

    // multiply by repeated addition, zero count then random count
    for (int t = 0; t < 2; t++) begin
      logic [15:0] x, y;
      clear_area();
      x = 16'($urandom);
      y = (t == 0) ? 16'd0 : 16'(1 + ($urandom % 20));
      poke(16'h3020, x); poke(16'h3021, y);
      emit_pcrel(4'h2, 3'd4, 16'h3020);
      emit_pcrel(4'h2, 3'd5, 16'h3021);
      emit(e_and_i(2, 2, 0));
      emit(e_add_i(5, 5, 0));
      emit_pcrel(4'h0, 3'b010, 16'h3008);
      emit(e_add_r(2, 2, 4));
      emit(e_add_i(5, 5, -1));
      emit_pcrel(4'h0, 3'b001, 16'h3005);
      emit_pcrel(4'h3, 3'd2, 16'h3022);
      halt();
      run(600);
      check("R12 multiply product", mem[mi(16'h3022)], 16'(x * y));
    end

    // random operate chains
    for (int rnd = 0; rnd < 4; rnd++) begin
      logic [15:0] last;
      clear_area();
      for (int k = 0; k < 8; k++) begin
        bm[k] = 16'($urandom);
        poke(16'h3080 + 16'(k), bm[k]);
      end
      for (int k = 0; k < 8; k++) emit_pcrel(4'h2, 3'(k), 16'h3080 + 16'(k));
      last = bm[7];
      emit(e_add_i(0, 0, -16)); bm[0] = bm[0] + 16'hFFF0;
      emit(e_not(1, 1));        bm[1] = ~bm[1];
      last = bm[1];
      for (int i = 0; i < 20; i++) begin
        int kind, d, s1, s2;
        logic [4:0] imm;
        kind = int'($urandom % 5); d = int'($urandom % 8);
        s1 = int'($urandom % 8); s2 = int'($urandom % 8);
        imm = 5'($urandom);
        case (kind)
          0: begin emit(e_add_r(d, s1, s2)); bm[d] = bm[s1] + bm[s2]; end
          1: begin emit(e_add_i(d, s1, int'(imm))); bm[d] = bm[s1] + sx5(imm); end
          2: begin emit(e_and_r(d, s1, s2)); bm[d] = bm[s1] & bm[s2]; end
          3: begin emit(e_and_i(d, s1, int'(imm))); bm[d] = bm[s1] & sx5(imm); end
          default: begin emit(e_not(d, s1)); bm[d] = ~bm[s1]; end
        endcase
        last = bm[d];
      end
      for (int k = 0; k < 8; k++) emit_pcrel(4'h3, 3'(k), 16'h30C0 + 16'(k));
      emit_flags(16'h30D0);
      halt();
      run(400);
      for (int k = 0; k < 8; k++)
        check($sformatf("R3/R4 register R%0d after random chain", k), mem[mi(16'h30C0 + 16'(k))], bm[k]);
      check("R5 flags from last operate (kept across stores)", mem[mi(16'h30D0)], fl(last));
    end

    // load, store, indirect and address generation
    for (int rnd = 0; rnd < 3; rnd++) begin
      logic [15:0] va, vb, vc;
      clear_area();
      va = (rnd == 1) ? 16'h0000 : (rnd == 2 ? (16'h8000 | 16'($urandom)) : 16'($urandom));
      vb = 16'($urandom); vc = 16'($urandom);
      poke(16'h3080, va); poke(16'h3082, vb); poke(16'h3083, 16'h3084);
      poke(16'h3084, vc); poke(16'h3085, 16'h3091);
      emit_pcrel(4'h2, 3'd1, 16'h3080);
      emit_pcrel(4'hE, 3'd2, 16'h3081);
      emit(e_base(4'h6, 3, 2, 1));
      emit_pcrel(4'hA, 3'd4, 16'h3083);
      emit(e_base(4'h7, 3, 2, 15));
      emit_pcrel(4'hB, 3'd4, 16'h3085);
      emit_pcrel(4'h3, 3'd2, 16'h3092);
      emit(e_base(4'h6, 5, 2, -1));
      emit_pcrel(4'h3, 3'd5, 16'h3093);
      emit_pcrel(4'h3, 3'd1, 16'h3094);
      emit_flags(16'h3095);
      halt();
      run(300);
      check("R6 LDR then STR positive offset", mem[mi(16'h3090)], vb);
      check("R7 LDI then STI through pointers", mem[mi(16'h3091)], vc);
      check("R8 LEA address value", mem[mi(16'h3092)], 16'h3081);
      check("R6 LDR negative offset", mem[mi(16'h3093)], va);
      check("R6 LD then ST PC-relative", mem[mi(16'h3094)], va);
      check("R5 flags from LDR value", mem[mi(16'h3095)], fl(va));
    end

    // register jump and vectored call
    clear_area();
    poke(16'h0042, 16'h0200);
    wp = 16'h0200;
    emit(e_and_i(2, 2, 0));
    emit(e_add_i(2, 2, 9));
    emit(e_jmp(7));
    wp = 16'h3000;
    emit(e_and_i(6, 6, 0));
    emit(e_add_i(6, 6, 5));
    emit_pcrel(4'hE, 3'd1, 16'h3005);
    emit(e_jmp(1));
    emit(e_add_i(6, 6, 1));
    emit(16'hF042);
    emit_pcrel(4'h3, 3'd6, 16'h3090);
    emit_pcrel(4'h3, 3'd7, 16'h3091);
    emit_pcrel(4'h3, 3'd2, 16'h3092);
    halt();
    run(200);
    check("R10 JMP skipped the word after it", mem[mi(16'h3090)], 16'd5);
    check("R11 TRAP saved return address in R7", mem[mi(16'h3091)], 16'h3006);
    check("R11 TRAP routine ran and returned", mem[mi(16'h3092)], 16'd9);

    report();
    $finish;
  end
endmodule